// File: doc/BRIEF.md
# Host-to-DMA Word FIFO Bridge

The bridge takes 16-bit words that a host processor writes one at a time and delivers them into the memory space of a second processor. It does this through a small word FIFO and a DMA-style drain engine. The host side holds a control word with a go flag and a remap flag, plus the source and destination address registers, a transfer length register and the FIFO write port. The FIFO level is reported back as a full flag in the control word.

The DMA side is programmed with a destination address and a transfer count through a load strobe. It is gated by a 2-bit channel mode input and a master enable. The drain runs only when the FIFO holds a nonzero multiple of four words, the mode is the push mode and the channel is enabled. It then emits one destination write per clock, stepping the address by two bytes for each word. The host length and the DMA count are kept separately and both count down as words leave. The go flag drops when the host length is used up. An end flag rises when the DMA count runs out, and any words the count cannot take are dropped.

Top module: `push_dma_bridge`

## Requirements
- R1: A write to the length register (select 5) stores the data with bits [1:0] forced to zero.
- R2: A FIFO write (select 6) while the go flag (control bit 2) is clear is discarded, and `h_reject` is high for exactly the one cycle after that write.
- R3: A drain starts only when the FIFO count is nonzero and a multiple of four, `dma_mode` is 2'b01 and `dma_master_en` is 1. A count of 1 to 3 words, or any other mode, produces no destination write.
- R4: A drain writes the words in FIFO order, one per consecutive clock. The first write goes to the loaded DMA address, and each later write goes two bytes above the one before.
- R5: Every destination write lowers the DMA count by 1 and the host length by 1 (the length stops at zero).
- R6: The full flag (control bit 7) is set exactly when the FIFO holds DEPTH words. FIFO writes made while it is full are discarded, and the flag clears once the drain removes words.
- R7: At the end of a drain, if the host length is zero, the go flag clears. Otherwise it stays set.
- R8: At the end of a drain, if the DMA count is zero, `dma_end` is set and the words left in the FIFO are discarded. A DMA load clears `dma_end`.
- R9: A control write (select 0) changes only the go flag (bit 2) and the remap flag (bit 0), and the full flag is kept.
- R10: If the FIFO already holds a nonzero multiple of four words when the mode becomes 2'b01 with the master enable set, a drain starts.
- R11: After reset the control word, length, DMA count, `dma_end`, `h_reject` and `dst_we` are all zero.
- R12: The address registers are written in 16-bit halves: select 1 and 2 set the source's upper and lower halves, and select 3 and 4 set the destination's upper and lower halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_wr_en | input | 1 | Host register write strobe |
| h_sel | input | 3 | Host register select (0 control, 1/2 source hi/lo, 3/4 destination hi/lo, 5 length, 6 FIFO) |
| h_wdata | input | 16 | Host write data |
| h_ctrl | output | 16 | Control word: bit 7 full, bit 2 go, bit 0 remap |
| h_len | output | 16 | Host length counter |
| h_src | output | AW | Host source address register |
| h_dst | output | AW | Host destination address register |
| h_reject | output | 1 | Pulse: a FIFO write arrived with go clear |
| dma_load | input | 1 | Load DMA address and count, clear end flag |
| dma_load_addr | input | AW | DMA destination start address |
| dma_load_cnt | input | TW | DMA transfer count in words |
| dma_mode | input | 2 | Channel mode; 2'b01 selects push transfers |
| dma_master_en | input | 1 | DMA master enable |
| dma_cnt | output | TW | Remaining DMA word count |
| dma_end | output | 1 | DMA count exhausted at the end of a drain |
| dst_we | output | 1 | Destination write strobe |
| dst_addr | output | AW | Destination write byte address |
| dst_data | output | 16 | Destination write data |

## Verification
The drain is tried with FIFO fills of three words, then four, and a full eight. This separates the multiple-of-four trigger from a level-based one. It is also run with the mode set to a non-push value and with the enable arriving after the FIFO is already full, which shows whether gating is checked at push time or continuously. A DMA count smaller than the FIFO fill, followed by a reload and fresh words, shows that the leftovers were discarded and not delivered later. A write rejected with go clear is followed by exactly DEPTH accepted writes, and full must rise on the last of these and not one earlier, which shows whether the rejected word was stored.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_SRC_HI = 3'd1,
        SEL_SRC_LO = 3'd2,
        SEL_DST_HI = 3'd3,
        SEL_DST_LO = 3'd4,
        SEL_LEN    = 3'd5,
        SEL_FIFO   = 3'd6,
        SEL_NONE   = 3'd7
    } host_sel_e;

    localparam int CTRL_MAP_BIT  = 0;
    localparam int CTRL_GO_BIT   = 2;
    localparam int CTRL_FULL_BIT = 7;

    localparam logic [1:0] MODE_PUSH = 2'b01;

    localparam int WORD_W = 16;

endpackage

// File: rtl/bridge_wordq.sv
module bridge_wordq #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t   st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic       do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;
    assign head  = mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full && !flush;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) st_d.wp = step(st_q.wp);
            if (do_pop)  st_d.rp = step(st_q.rp);
            if (do_push && !do_pop)
                st_d.cnt = st_q.cnt + CW'(1);
            else if (!do_push && do_pop)
                st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_data;
    end

endmodule

// File: rtl/bridge_drain.sv
module bridge_drain
    import bridge_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 24,
    parameter int CW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     fifo_cnt,
    input  logic [WORD_W-1:0] head,
    input  logic [1:0]        mode,
    input  logic              master_en,
    input  logic              load,
    input  logic [AW-1:0]     load_addr,
    input  logic [TW-1:0]     load_cnt,
    output logic              pop,
    output logic              flush,
    output logic              done,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [TW-1:0]     cnt_o,
    output logic              end_o
);
    typedef struct packed {
        logic          running;
        logic [AW-1:0] addr;
        logic [TW-1:0] tcr;
        logic [CW-1:0] left;
        logic          endf;
    } dr_state_t;

    dr_state_t st_d, st_q;
    logic      trigger;
    logic      fits;

    assign wr_en   = st_q.running && (st_q.left != '0);
    assign pop     = wr_en;
    assign wr_addr = st_q.addr;
    assign wr_data = head;
    assign done    = st_q.running && (st_q.left == '0);
    assign flush   = done && (st_q.tcr == '0);
    assign cnt_o   = st_q.tcr;
    assign end_o   = st_q.endf;

    always_comb begin
        st_d    = st_q;
        trigger = !st_q.running && (fifo_cnt != '0) && (fifo_cnt[1:0] == 2'b00)
                  && (mode == MODE_PUSH) && master_en;
        fits    = ({{(TW-CW){1'b0}}, fifo_cnt} <= st_q.tcr);

        if (trigger) begin
            st_d.running = 1'b1;
            st_d.left    = fits ? fifo_cnt : st_q.tcr[CW-1:0];
        end else if (wr_en) begin
            st_d.addr = st_q.addr + AW'(2);
            st_d.tcr  = st_q.tcr - TW'(1);
            st_d.left = st_q.left - CW'(1);
        end else if (done) begin
            st_d.running = 1'b0;
            if (st_q.tcr == '0) st_d.endf = 1'b1;
        end

        if (load) begin
            st_d.addr = load_addr;
            st_d.tcr  = load_cnt;
            st_d.endf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/push_dma_bridge.sv
module push_dma_bridge
    import bridge_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int TW    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr_en,
    input  logic [2:0]        h_sel,
    input  logic [15:0]       h_wdata,
    output logic [15:0]       h_ctrl,
    output logic [15:0]       h_len,
    output logic [AW-1:0]     h_src,
    output logic [AW-1:0]     h_dst,
    output logic              h_reject,
    input  logic              dma_load,
    input  logic [AW-1:0]     dma_load_addr,
    input  logic [TW-1:0]     dma_load_cnt,
    input  logic [1:0]        dma_mode,
    input  logic              dma_master_en,
    output logic [TW-1:0]     dma_cnt,
    output logic              dma_end,
    output logic              dst_we,
    output logic [AW-1:0]     dst_addr,
    output logic [15:0]       dst_data
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int HW = AW / 2;

    typedef struct packed {
        logic          go;
        logic          map;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [15:0]   len;
        logic          reject;
    } host_state_t;

    host_state_t hs_d, hs_q;
    host_sel_e   sel;
    logic        fifo_push, fifo_pop, fifo_flush, fifo_full, drain_done;
    logic [CW-1:0]     fifo_cnt;
    logic [WORD_W-1:0] fifo_head;

    assign sel       = host_sel_e'(h_sel);
    assign fifo_push = h_wr_en && (sel == SEL_FIFO) && hs_q.go;

    always_comb begin
        hs_d        = hs_q;
        hs_d.reject = 1'b0;

        if (fifo_pop && (hs_q.len != '0))
            hs_d.len = hs_q.len - 16'd1;

        if (h_wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    hs_d.go  = h_wdata[CTRL_GO_BIT];
                    hs_d.map = h_wdata[CTRL_MAP_BIT];
                end
                SEL_SRC_HI: hs_d.src[AW-1:HW] = h_wdata[HW-1:0];
                SEL_SRC_LO: hs_d.src[HW-1:0]  = h_wdata[HW-1:0];
                SEL_DST_HI: hs_d.dst[AW-1:HW] = h_wdata[HW-1:0];
                SEL_DST_LO: hs_d.dst[HW-1:0]  = h_wdata[HW-1:0];
                SEL_LEN:    hs_d.len = {h_wdata[15:2], 2'b00};
                SEL_FIFO:   if (!hs_q.go) hs_d.reject = 1'b1;
                default: ;
            endcase
        end

        if (drain_done && (hs_q.len == '0))
            hs_d.go = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    always_comb begin
        h_ctrl                = '0;
        h_ctrl[CTRL_FULL_BIT] = fifo_full;
        h_ctrl[CTRL_GO_BIT]   = hs_q.go;
        h_ctrl[CTRL_MAP_BIT]  = hs_q.map;
    end

    assign h_len    = hs_q.len;
    assign h_src    = hs_q.src;
    assign h_dst    = hs_q.dst;
    assign h_reject = hs_q.reject;

    bridge_wordq #(.DEPTH(DEPTH), .W(WORD_W), .CW(CW)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (h_wdata),
        .pop       (fifo_pop),
        .flush     (fifo_flush),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .full      (fifo_full)
    );

    bridge_drain #(.AW(AW), .TW(TW), .CW(CW)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_cnt  (fifo_cnt),
        .head      (fifo_head),
        .mode      (dma_mode),
        .master_en (dma_master_en),
        .load      (dma_load),
        .load_addr (dma_load_addr),
        .load_cnt  (dma_load_cnt),
        .pop       (fifo_pop),
        .flush     (fifo_flush),
        .done      (drain_done),
        .wr_en     (dst_we),
        .wr_addr   (dst_addr),
        .wr_data   (dst_data),
        .cnt_o     (dma_cnt),
        .end_o     (dma_end)
    );

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
    parameter int AW = 32,
    parameter int TW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          go,
    input logic          h_reject,
    input logic          dma_load,
    input logic [1:0]    dma_mode,
    input logic          dma_master_en,
    input logic [TW-1:0] dma_cnt,
    input logic          dma_end,
    input logic          dst_we,
    input logic [AW-1:0] dst_addr
);
    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && $past(dst_we)) |-> (dst_addr == $past(dst_addr) + AW'(2)));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && !dma_load) |=> (dma_cnt == $past(dma_cnt) - TW'(1)));

    // R5
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (dma_cnt != '0));

    // R3
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dst_we) |-> (($past(dma_mode) == 2'b01) && $past(dma_master_en)));

    // R8
    end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_end) |-> (dma_cnt == '0));

    // R2
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_reject |-> !$past(go));

endmodule

bind push_dma_bridge bridge_chk #(.AW(AW), .TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (h_ctrl[2]),
    .h_reject      (h_reject),
    .dma_load      (dma_load),
    .dma_mode      (dma_mode),
    .dma_master_en (dma_master_en),
    .dma_cnt       (dma_cnt),
    .dma_end       (dma_end),
    .dst_we        (dst_we),
    .dst_addr      (dst_addr)
);

// File: tb/push_dma_bridge_tb.sv
module push_dma_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr_en = 1'b0;
    logic [2:0]  h_sel = 3'd7;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_ctrl, h_len;
    logic [31:0] h_src, h_dst;
    logic        h_reject;
    logic        dma_load = 1'b0;
    logic [31:0] dma_load_addr = '0;
    logic [23:0] dma_load_cnt = '0;
    logic [1:0]  dma_mode = 2'b00;
    logic        dma_master_en = 1'b0;
    logic [23:0] dma_cnt;
    logic        dma_end, dst_we;
    logic [31:0] dst_addr;
    logic [15:0] dst_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int cap_n = 0;
    logic [31:0] cap_a [64];
    logic [15:0] cap_d [64];
    int          cap_t [64];

    always #2 clk = ~clk;

    push_dma_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .h_wr_en(h_wr_en), .h_sel(h_sel), .h_wdata(h_wdata),
        .h_ctrl(h_ctrl), .h_len(h_len), .h_src(h_src), .h_dst(h_dst), .h_reject(h_reject),
        .dma_load(dma_load), .dma_load_addr(dma_load_addr), .dma_load_cnt(dma_load_cnt),
        .dma_mode(dma_mode), .dma_master_en(dma_master_en), .dma_cnt(dma_cnt),
        .dma_end(dma_end), .dst_we(dst_we), .dst_addr(dst_addr), .dst_data(dst_data)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n && dst_we && cap_n < 64) begin
            cap_a[cap_n] = dst_addr;
            cap_d[cap_n] = dst_data;
            cap_t[cap_n] = cyc;
            cap_n++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        h_wr_en = 1'b1; h_sel = sel; h_wdata = d;
        @(negedge clk);
        h_wr_en = 1'b0; h_sel = 3'd7;
    endtask

    task automatic dcfg(input logic [31:0] a, input logic [23:0] n);
        @(negedge clk);
        dma_load = 1'b1; dma_load_addr = a; dma_load_cnt = n;
        @(negedge clk);
        dma_load = 1'b0;
    endtask

    task automatic expect_writes(input string tag, input int base, input int n,
                                 input logic [31:0] a0, input logic [15:0] d0);
        chk({tag, " write count"}, cap_n - base, n);
        for (int i = 0; i < n; i++) begin
            chk({tag, " R4 addr"}, cap_a[base+i], a0 + 32'(2*i));
            chk({tag, " R4 data"}, {16'h0, cap_d[base+i]}, {16'h0, d0 + 16'(i)});
            if (i > 0) chk({tag, " R4 back-to-back"}, cap_t[base+i], cap_t[base+i-1] + 1);
        end
    endtask

    task automatic t_reset();
        chk("R11 ctrl", {16'h0, h_ctrl}, 0);
        chk("R11 len", {16'h0, h_len}, 0);
        chk("R11 dma_cnt", {8'h0, dma_cnt}, 0);
        chk("R11 dma_end", {31'h0, dma_end}, 0);
        chk("R11 reject", {31'h0, h_reject}, 0);
        chk("R11 dst_we", {31'h0, dst_we}, 0);
    endtask

    task automatic t_len_addr();
        hwr(3'd5, 16'h0013);
        chk("R1 len 0013", {16'h0, h_len}, 32'h0010);
        hwr(3'd5, 16'hFFFF);
        chk("R1 len FFFF", {16'h0, h_len}, 32'hFFFC);
        hwr(3'd1, 16'h1234); hwr(3'd2, 16'h5678);
        chk("R12 src", h_src, 32'h12345678);
        hwr(3'd3, 16'h0600); hwr(3'd4, 16'h0040);
        chk("R12 dst", h_dst, 32'h06000040);
    endtask

    task automatic t_reject();
        hwr(3'd6, 16'hDEAD);
        chk("R2 reject pulse", {31'h0, h_reject}, 1);
        ticks(1);
        chk("R2 reject one cycle", {31'h0, h_reject}, 0);
    endtask

    task automatic t_full_ctrl();
        int base;
        base = cap_n;
        dcfg(32'h06000000, 24'd8);
        hwr(3'd5, 16'd8);
        hwr(3'd0, 16'h0004);
        chk("R9 go set", {16'h0, h_ctrl}, 32'h0004);
        for (int i = 0; i < 7; i++) hwr(3'd6, 16'h1000 + 16'(i));
        chk("R2 R6 not full at 7", {31'h0, h_ctrl[7]}, 0);
        hwr(3'd6, 16'h1007);
        chk("R6 full at depth", {31'h0, h_ctrl[7]}, 1);
        hwr(3'd6, 16'hBEEF);
        hwr(3'd0, 16'h0005);
        chk("R9 full kept map set", {16'h0, h_ctrl}, 32'h0085);
        hwr(3'd0, 16'h0004);
        chk("R9 map cleared", {16'h0, h_ctrl}, 32'h0084);
        ticks(4);
        chk("R3 disabled no writes", cap_n - base, 0);
        // R10: enable arrives with the FIFO already holding eight words
        @(negedge clk); dma_mode = 2'b01; dma_master_en = 1'b1;
        ticks(16);
        expect_writes("R10 late enable", base, 8, 32'h06000000, 16'h1000);
        chk("R6 full cleared", {31'h0, h_ctrl[7]}, 0);
        chk("R5 dma_cnt zero", {8'h0, dma_cnt}, 0);
        chk("R5 len zero", {16'h0, h_len}, 0);
        chk("R8 end set", {31'h0, dma_end}, 1);
        chk("R7 go cleared", {16'h0, h_ctrl}, 0);
    endtask

    task automatic t_partial();
        int base;
        dcfg(32'h06000100, 24'd16);
        chk("R8 load clears end", {31'h0, dma_end}, 0);
        hwr(3'd5, 16'd16);
        hwr(3'd0, 16'h0004);
        base = cap_n;
        for (int i = 0; i < 3; i++) hwr(3'd6, 16'h2000 + 16'(i));
        ticks(6);
        chk("R3 three words no drain", cap_n - base, 0);
        hwr(3'd6, 16'h2003);
        ticks(10);
        expect_writes("R3 four words", base, 4, 32'h06000100, 16'h2000);
        chk("R5 dma_cnt 12", {8'h0, dma_cnt}, 12);
        chk("R5 len 12", {16'h0, h_len}, 12);
        chk("R7 go stays", {16'h0, h_ctrl}, 32'h0004);
        chk("R8 end stays clear", {31'h0, dma_end}, 0);
    endtask

    task automatic t_trunc();
        int base;
        dcfg(32'h06000200, 24'd2);
        base = cap_n;
        for (int i = 0; i < 4; i++) hwr(3'd6, 16'h3000 + 16'(i));
        ticks(12);
        expect_writes("R8 truncated", base, 2, 32'h06000200, 16'h3000);
        chk("R8 end on zero count", {31'h0, dma_end}, 1);
        chk("R8 dma_cnt zero", {8'h0, dma_cnt}, 0);
        chk("R5 len 10", {16'h0, h_len}, 10);
        dcfg(32'h06000300, 24'd4);
        chk("R8 reload clears end", {31'h0, dma_end}, 0);
        base = cap_n;
        for (int i = 0; i < 4; i++) hwr(3'd6, 16'h4000 + 16'(i));
        ticks(12);
        expect_writes("R8 leftovers dropped", base, 4, 32'h06000300, 16'h4000);
        chk("R5 len 6", {16'h0, h_len}, 6);
    endtask

    task automatic t_mode();
        int base;
        dcfg(32'h06000400, 24'd4);
        @(negedge clk); dma_mode = 2'b10;
        base = cap_n;
        for (int i = 0; i < 4; i++) hwr(3'd6, 16'h5000 + 16'(i));
        ticks(8);
        chk("R3 other mode no drain", cap_n - base, 0);
        @(negedge clk); dma_mode = 2'b01;
        ticks(12);
        expect_writes("R10 mode switch", base, 4, 32'h06000400, 16'h5000);
        chk("R5 len 2", {16'h0, h_len}, 2);
        chk("R8 end after mode drain", {31'h0, dma_end}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ticks(1);
        t_reset();
        t_len_addr();
        t_reject();
        t_full_ctrl();
        t_partial();
        t_trunc();
        t_mode();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule